// File: doc/BRIEF.md
# Superpage Virtual-to-Physical Mapper

This block checks a 48-bit virtual address against three fixed superpage windows. When a window is enabled and the address falls inside it, the block forms a 44-bit physical address directly from the virtual address, with no TLB lookup. Each window forms the physical address in its own way. The widest window copies the address straight through and drops two unused upper bits. The middle window sign-extends from one bit. The smallest window zero-fills everything above its copied field. The low 13 bits, which are the page offset, always pass through unchanged.

A three-bit enable field is held in a write-only control register that resets to zero. A lookup issued with `va_valid` returns its result on the next cycle, and a new lookup may start every cycle. A hit while the access is not privileged (not kernel mode) is reported as an access violation, and no physical address is returned. An address that lands in no enabled window is reported as a miss, so the caller can handle it.

Top module: `sp_mapper`

## Requirements
- R1: After reset, `out_valid`, `hit` and `acc_viol` are 0. All three enables are 0, so a privileged lookup of an address inside any window returns a miss.
- R2: Window 2 (enable bit 2) matches when va[47:46] = 2'b10. On a privileged hit, pa[43:0] = va[43:0], and va[45:44] have no effect.
- R3: Window 1 (enable bit 1) matches when va[47:41] = 7'h7E. On a privileged hit, pa[40:0] = va[40:0] and pa[43:41] are three copies of va[40].
- R4: Window 0 (enable bit 0) matches when va[47:30] = 18'h3FFFE. On a privileged hit, pa[29:0] = va[29:0] and pa[43:30] = 0.
- R5: On every hit, pa[12:0] equals va[12:0] of the lookup that produced it.
- R6: A valid lookup that matches no enabled window gives `hit` = 0, `acc_viol` = 0 and `pa` = 0.
- R7: A valid lookup with `kernel_mode` = 0 that matches an enabled window gives `acc_viol` = 1, `hit` = 0 and `pa` = 0. `hit` and `acc_viol` are never high together.
- R8: `out_valid` is `va_valid` delayed by one clock. A new lookup is accepted every cycle.
- R9: The three window match conditions never hold at the same time for any address.
- R10: A write of `cfg_en` with `cfg_wr` = 1 takes effect for lookups issued on later cycles. A lookup issued in the same cycle as the write uses the old enables.
- R11: While `out_valid` is 0, `hit` and `acc_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the window-enable register |
| cfg_en | input | 3 | New window enables; bit n enables window n |
| va_valid | input | 1 | Lookup strobe |
| va | input | 48 | Virtual address |
| kernel_mode | input | 1 | 1 when the access is privileged |
| out_valid | output | 1 | Result valid, one cycle after `va_valid` |
| hit | output | 1 | Privileged access inside an enabled window |
| acc_viol | output | 1 | Unprivileged access inside an enabled window |
| pa | output | 44 | Physical address on a hit, otherwise 0 |

## Verification
The hardest cases to reach from the ports are addresses that lie just outside a window. Examples are tags that differ by one from a window tag, and prefixes such as 7'h7F, which belong to window 0 only when bit 30 is also clear. Uniformly random addresses would almost never land on these. The stimulus therefore builds each address from a chosen tag pattern, both the exact window tags and their near neighbours, and fills the remaining bits with all-zero, all-one and pseudo-random values. Every such address is swept under all eight enable settings and both privilege levels. The enable writes happen in the same cycle as a lookup, so the old-value rule of R10 is exercised on each change.

// File: rtl/sp_mapper_pkg.sv
package sp_mapper_pkg;

  typedef enum logic [0:0] {
    FILL_ZERO = 1'b0,
    FILL_SIGN = 1'b1
  } fill_e;

  localparam int unsigned SP_NREG = 3;

  // per-window: lowest tag bit, tag value, highest copied bit, upper fill rule
  localparam int unsigned SP_TAG_LO  [SP_NREG] = '{30, 41, 46};
  localparam logic [31:0] SP_TAG_VAL [SP_NREG] = '{32'h3FFFE, 32'h7E, 32'h2};
  localparam int unsigned SP_COPY_HI [SP_NREG] = '{29, 40, 43};
  localparam fill_e       SP_FILL    [SP_NREG] = '{FILL_ZERO, FILL_SIGN, FILL_ZERO};

endpackage

// File: rtl/sp_cfg_reg.sv
module sp_cfg_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q
);

  logic [N-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr) begin
      en_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/sp_region_dec.sv
module sp_region_dec
  import sp_mapper_pkg::*;
#(
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 44,
  parameter int unsigned TAG_LO  = 30,
  parameter logic [31:0] TAG_VAL = 32'h3FFFE,
  parameter int unsigned COPY_HI = 29,
  parameter fill_e       FILL    = FILL_ZERO
) (
  input  logic [VA_W-1:0] va,
  output logic            match,
  output logic [PA_W-1:0] pa_cand
);

  localparam int unsigned TW = VA_W - TAG_LO;

  logic unused_va;
  assign unused_va = ^va;

  always_comb begin
    match = (va[VA_W-1:TAG_LO] == TAG_VAL[TW-1:0]);
    for (int i = 0; i < PA_W; i++) begin
      if (i <= COPY_HI) begin
        pa_cand[i] = va[i];
      end else if (FILL == FILL_SIGN) begin
        pa_cand[i] = va[COPY_HI];
      end else begin
        pa_cand[i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/sp_resolve.sv
module sp_resolve #(
  parameter int unsigned N    = 3,
  parameter int unsigned PA_W = 44
) (
  input  logic [N-1:0]           match,
  input  logic [N-1:0][PA_W-1:0] cand,
  input  logic [N-1:0]           en,
  input  logic                   kernel,
  output logic                   sel_hit,
  output logic                   sel_viol,
  output logic [PA_W-1:0]        sel_pa
);

  logic [N-1:0]    active;
  logic            any_active;
  logic [PA_W-1:0] pa_or;

  always_comb begin
    active     = match & en;
    any_active = |active;
    pa_or      = '0;
    for (int r = 0; r < N; r++) begin
      pa_or = pa_or | (cand[r] & {PA_W{active[r]}});
    end
    sel_hit  = any_active & kernel;
    sel_viol = any_active & ~kernel;
    sel_pa   = sel_hit ? pa_or : '0;
  end

endmodule

// File: rtl/sp_mapper.sv
module sp_mapper
  import sp_mapper_pkg::*;
#(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned PA_W  = 44,
  parameter int unsigned OFF_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SP_NREG-1:0] cfg_en,
  input  logic              va_valid,
  input  logic [VA_W-1:0]   va,
  input  logic              kernel_mode,
  output logic              out_valid,
  output logic              hit,
  output logic              acc_viol,
  output logic [PA_W-1:0]   pa
);

  localparam int unsigned N = SP_NREG;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [N-1:0] en_q;

  sp_cfg_reg #(.N(N)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (cfg_wr),
    .wdata (cfg_en),
    .en_q  (en_q)
  );

  logic [N-1:0]           region_match;
  logic [N-1:0][PA_W-1:0] region_pa;

  for (genvar g = 0; g < N; g++) begin : g_win
    sp_region_dec #(
      .VA_W    (VA_W),
      .PA_W    (PA_W),
      .TAG_LO  (SP_TAG_LO[g]),
      .TAG_VAL (SP_TAG_VAL[g]),
      .COPY_HI (SP_COPY_HI[g]),
      .FILL    (SP_FILL[g])
    ) u_dec (
      .va      (va),
      .match   (region_match[g]),
      .pa_cand (region_pa[g])
    );
  end

  logic            sel_hit;
  logic            sel_viol;
  logic [PA_W-1:0] sel_pa;

  sp_resolve #(.N(N), .PA_W(PA_W)) u_res (
    .match    (region_match),
    .cand     (region_pa),
    .en       (en_q),
    .kernel   (kernel_mode),
    .sel_hit  (sel_hit),
    .sel_viol (sel_viol),
    .sel_pa   (sel_pa)
  );

  // output stage
  logic            valid_d, hit_d, viol_d, pa_ce;
  logic [PA_W-1:0] pa_d;

  always_comb begin
    valid_d = va_valid;
    hit_d   = va_valid & sel_hit;
    viol_d  = va_valid & sel_viol;
    pa_ce   = va_valid;
    pa_d    = sel_pa;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      hit       <= 1'b0;
      acc_viol  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      hit       <= hit_d;
      acc_viol  <= viol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pa <= '0;
    end else if (pa_ce) begin
      pa <= pa_d;
    end
  end

endmodule

// File: rtl/sp_mapper_chk.sv
module sp_mapper_chk #(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned PA_W  = 44,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned N     = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            va_valid,
  input logic [VA_W-1:0] va,
  input logic            kernel_mode,
  input logic [N-1:0]    region_match,
  input logic            out_valid,
  input logic            hit,
  input logic            acc_viol,
  input logic [PA_W-1:0] pa
);

  // R9
  onehot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_match));

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    va_valid |=> out_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !va_valid |=> !out_valid);

  // R7
  hit_viol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && acc_viol));

  // R7
  user_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (va_valid && !kernel_mode) |=> !hit);

  // R6
  miss_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hit) |-> (pa == '0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!hit && !acc_viol));

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    va_valid |=> (!hit || (pa[OFF_W-1:0] == $past(va[OFF_W-1:0]))));

endmodule

bind sp_mapper sp_mapper_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W),
  .N     (N)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .va_valid     (va_valid),
  .va           (va),
  .kernel_mode  (kernel_mode),
  .region_match (region_match),
  .out_valid    (out_valid),
  .hit          (hit),
  .acc_viol     (acc_viol),
  .pa           (pa)
);

// File: tb/tb_sp_mapper.sv
`timescale 1ns/1ps
module tb_sp_mapper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_en;
  logic        va_valid;
  logic [47:0] va;
  logic        kernel_mode;
  logic        out_valid, hit, acc_viol;
  logic [43:0] pa;

  always #2.5 clk = ~clk;

  sp_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .va_valid(va_valid), .va(va), .kernel_mode(kernel_mode),
    .out_valid(out_valid), .hit(hit), .acc_viol(acc_viol), .pa(pa)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        e_valid = 1'b0, e_hit = 1'b0, e_viol = 1'b0;
  logic [43:0] e_pa = '0;
  logic [47:0] e_va = '0;
  string       e_tag = "R1";
  logic [2:0]  m_en = 3'b000;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic model(input logic [47:0] a, input logic [2:0] en, input logic k,
                       output logic h, output logic v, output logic [43:0] p,
                       output string tag);
    logic m2, m1, m0;
    m2 = (a[47:46] == 2'b10)       && en[2];
    m1 = (a[47:41] == 7'h7E)       && en[1];
    m0 = (a[47:30] == 18'h3FFFE)   && en[0];
    h = 1'b0; v = 1'b0; p = '0;
    if (!(m2 || m1 || m0)) begin
      tag = "R6";
    end else if (!k) begin
      v = 1'b1; tag = "R7";
    end else begin
      h = 1'b1;
      if (m2) begin
        p = a[43:0]; tag = "R2";
      end else if (m1) begin
        p = {{3{a[40]}}, a[40:0]}; tag = "R3";
      end else begin
        p = {14'd0, a[29:0]}; tag = "R4";
      end
    end
  endtask

  task automatic check_prev();
    n_run++;
    if (out_valid !== e_valid || hit !== e_hit || acc_viol !== e_viol ||
        (e_valid && pa !== e_pa)) begin
      n_fail++;
      $display("FAIL %s: got v=%b h=%b x=%b pa=%h, exp v=%b h=%b x=%b pa=%h (va=%h)",
               e_tag, out_valid, hit, acc_viol, pa, e_valid, e_hit, e_viol, e_pa, e_va);
    end
    if (e_valid && e_hit) begin
      n_run++;
      if (pa[12:0] !== e_va[12:0]) begin
        n_fail++;
        $display("FAIL R5: got offset %h, exp %h", pa[12:0], e_va[12:0]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [47:0] a, input logic k,
                      input logic wr, input logic [2:0] wd, input string force_tag);
    logic h, x;
    logic [43:0] p;
    string t;
    @(negedge clk);
    check_prev();
    va_valid = v; va = a; kernel_mode = k; cfg_wr = wr; cfg_en = wd;
    model(a, m_en, k, h, x, p, t);
    e_valid = v; e_va = a;
    e_hit = v & h; e_viol = v & x; e_pa = (v & h) ? p : 44'd0;
    if (!v) t = "R11";
    if (wr) t = "R10";
    if (force_tag != "") t = force_tag;
    e_tag = t;
    if (wr) m_en = wd;
  endtask

  function automatic logic [47:0] mk_va(input int pat, input logic [47:0] r);
    case (pat)
      0: return {2'b10, r[45:0]};
      1: return {7'h7E, r[40:0]};
      2: return {18'h3FFFE, r[29:0]};
      3: return {7'h7F, r[40:0]};
      4: return {18'h3FFFF, r[29:0]};
      5: return {18'h3FFFD, r[29:0]};
      6: return {2'b01, r[45:0]};
      default: return {2'b11, r[45:0]};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] r;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_en = '0; va_valid = 1'b0; va = '0; kernel_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    n_run++;
    if (out_valid !== 1'b0 || hit !== 1'b0 || acc_viol !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got v=%b h=%b x=%b, exp 0 0 0", out_valid, hit, acc_viol);
    end
    // R1: enables cleared, in-window privileged lookups miss
    for (int p = 0; p < 3; p++) begin
      step(1'b1, mk_va(p, 48'h0000_5555_AAAA), 1'b1, 1'b0, 3'b000, "R1");
    end
    // sweep: every enable setting, both privilege levels, tag patterns, filler bits
    for (int en = 0; en < 8; en++) begin
      step(1'b1, mk_va(en % 3, 48'h1111_2222_3333), 1'b1, 1'b1, en[2:0], "");
      for (int k = 0; k < 2; k++) begin
        for (int p = 0; p < 8; p++) begin
          for (int j = 0; j < 16; j++) begin
            if (j == 0) r = '0;
            else if (j == 1) r = '1;
            else begin
              seed = xs(seed); r[31:0] = seed;
              seed = xs(seed); r[47:32] = seed[15:0];
            end
            step((j % 5) != 4, mk_va(p, r), k[0], 1'b0, 3'b000, "");
          end
        end
      end
    end
    // R8: back-to-back lookups then idle
    step(1'b1, {2'b10, 46'h1234_5678_9ABC}, 1'b1, 1'b0, 3'b000, "R8");
    step(1'b1, {18'h3FFFE, 30'h2AAA_AAAA}, 1'b1, 1'b0, 3'b000, "R8");
    step(1'b0, '0, 1'b0, 1'b0, 3'b000, "R8");
    @(negedge clk);
    check_prev();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule